// File: doc/BRIEF.md
# Program/Erase Sequencer with Polled Status

This block runs the internally timed write operations of a blocked non-volatile array. A command decoder in front of it hands over one request at a time. The request can program a single byte or a single 16-bit word, erase a chosen set of equal-sized blocks, erase the whole array, suspend or resume a running erase, or abandon a suspended erase. The sequencer times every operation with clock-cycle counters. It drives the write port of an external array and passes host reads through to the array's read port.

While an operation runs, a host read returns a status byte instead of array data. Bit 7 is a data-polling flag. Bit 6 toggles on every status read while the sequencer is busy. Bit 2 toggles only on reads aimed at a block that is being erased. An active-low `ready_n` output shows when the sequencer is busy. A block erase can be suspended, so that other blocks can be read or programmed, and then resumed where it stopped. Requests aimed only at protected blocks finish after a short fixed time and change nothing.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, `ready_n` is 1 and every read returns array data from `arr_rdata` for the address `rd_addr`.
- R2: A word program (op code 2) keeps `ready_n` low for PROG_WORD_CYC cycles. It then writes old AND data to the addressed word.
- R3: A byte program (op code 1) takes PROG_BYTE_CYC cycles and ANDs `req_data[7:0]` into the byte lane that `req_lane` selects (1 selects bits 15:8). The other lane is left unchanged.
- R4: A program never changes a bit from 0 to 1.
- R5: A selective erase (op code 3, mask in `req_blk_mask`) sets every word of each chosen unprotected block to 16'hFFFF and leaves all other blocks unchanged. It is busy for ERASE_CELL_CYC cycles per erased word plus one cycle per other word.
- R6: A chip erase (op code 4) erases every unprotected block. Blocks marked in `prot_mask` keep their contents.
- R7: A program whose target block is protected, or an erase whose chosen blocks are all protected, holds `ready_n` low for REJ_CYC cycles and writes nothing.
- R8: A status read returns `{8'h00, poll, t6, 3'b000, t2, 2'b00}`. The `poll` bit is the complement of data bit 7 during a program, 0 during an erase, and 1 while an erase is suspended. Every read is a status read while the sequencer is busy.
- R9: Bit 6 inverts after each status read while the sequencer is busy. It keeps its value during status reads of a suspended erase.
- R10: Bit 2 inverts after a status read only when the read address lies in a block that the running or suspended erase has chosen.
- R11: A suspend (op code 5) during an erase freezes the erase and sets `ready_n` high. Reads of blocks outside the erase return array data, and reads of blocks inside it return status.
- R12: While an erase is suspended, a program to a block outside the erase runs and then returns to the suspended state. A program to a block inside the erase is ignored. Requests other than suspend are ignored while the sequencer is busy.
- R13: A resume (op code 6) continues a suspended erase from the word where it stopped. An abandon (op code 7) drops the suspended erase and returns to array read.
- R14: Asserting `rst` during any operation stops it. From the next cycle `ready_n` is 1 and reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts any operation |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 3 | Op code: 1 byte program, 2 word program, 3 selective erase, 4 chip erase, 5 suspend, 6 resume, 7 abandon |
| req_addr | input | AW | Word address of a program |
| req_lane | input | 1 | Byte lane of a byte program (1 = upper) |
| req_data | input | 16 | Program data (byte program uses bits 7:0) |
| req_blk_mask | input | NUM_BLK | Blocks chosen by a selective erase |
| prot_mask | input | NUM_BLK | Protected blocks, sampled when a request is accepted |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read word address |
| rd_data | output | 16 | Array data or status byte |
| ready_n | output | 1 | Low while an operation is running |
| arr_raddr | output | AW | Array read address |
| arr_rdata | input | 16 | Array read data |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | AW | Array write address |
| wr_data | output | 16 | Array write data |
| wr_old | input | 16 | Current array content at `wr_addr` |

## Verification
On every cycle, the assertions check several properties. A program write only clears bits, relative to the word it replaces. Erase writes are all ones. Program and erase never write in the same cycle. Nothing is written while idle or while a protected request is being refused. A suspended erase neither advances nor reports busy. The exact busy lengths, the placement of byte lanes, the status bit values and their toggling across successive reads, and resuming from the right word can only be shown by the bench scenarios. There, a behavioural model predicts `ready_n` and the whole array on every clock.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_PROG_BYTE = 3'd1,
        OP_PROG_WORD = 3'd2,
        OP_ERASE_SEL = 3'd3,
        OP_ERASE_ALL = 3'd4,
        OP_SUSPEND   = 3'd5,
        OP_RESUME    = 3'd6,
        OP_ABANDON   = 3'd7
    } pec_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_REJ
    } pec_state_e;

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Program can only pull bits low: the selected lane is ANDed in.
    function automatic logic [WORD_W-1:0] prog_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] data,
        input logic              is_byte,
        input logic              lane
    );
        logic [WORD_W-1:0] m;
        if (!is_byte)  m = data;
        else if (lane) m = {data[7:0], 8'hFF};
        else           m = {8'hFF, data[7:0]};
        return old_w & m;
    endfunction

    function automatic logic [7:0] pack_status(input logic poll, input logic t6, input logic t2);
        return {poll, t6, 3'b000, t2, 2'b00};
    endfunction

endpackage

// File: rtl/pec_erase_walk.sv
module pec_erase_walk #(
    parameter int NUM_BLK   = 4,
    parameter int BLK_WORDS = 8,
    parameter int CELL_CYC  = 4,
    parameter int AW        = $clog2(NUM_BLK * BLK_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic [NUM_BLK-1:0] blk_mask,
    output logic               we,
    output logic [AW-1:0]      addr,
    output logic               done
);
    localparam int BW = $clog2(BLK_WORDS);
    localparam int CW = $clog2(CELL_CYC + 1);
    localparam logic [AW-1:0] LAST   = AW'(NUM_BLK * BLK_WORDS - 1);
    localparam logic [CW-1:0] RELOAD = CW'(CELL_CYC - 1);

    logic [AW-1:0] cur;
    logic [CW-1:0] cnt;
    logic          sel;
    logic          adv;

    assign sel  = blk_mask[cur[AW-1:BW]];
    assign adv  = run && (!sel || cnt == '0);
    assign we   = run && sel && cnt == '0;
    assign done = adv && cur == LAST;
    assign addr = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= RELOAD;
        end else if (start) begin
            cur <= '0;
            cnt <= RELOAD;
        end else if (adv) begin
            cur <= cur + 1'b1;
            cnt <= RELOAD;
        end else if (run) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_WALK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> ($stable(cur) && $stable(cnt))); // R11

endmodule

// File: rtl/pec_status.sv
module pec_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       stat_rd,
    input  logic       running,
    input  logic       blk_hit,
    input  logic       poll,
    output logic [7:0] status
);
    import pec_pkg::*;

    logic t6;
    logic t2;

    always_ff @(posedge clk) begin
        if (rst) begin
            t6 <= 1'b0;
            t2 <= 1'b0;
        end else begin
            if (stat_rd && running) t6 <= ~t6;
            if (stat_rd && blk_hit) t2 <= ~t2;
        end
    end

    assign status = pack_status(poll, t6, t2);

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
    import pec_pkg::*;
#(
    parameter int NUM_BLK        = 4,
    parameter int BLK_WORDS      = 8,
    parameter int PROG_BYTE_CYC  = 10,
    parameter int PROG_WORD_CYC  = 16,
    parameter int ERASE_CELL_CYC = 4,
    parameter int REJ_CYC        = 3,
    parameter int AW             = $clog2(NUM_BLK * BLK_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_lane,
    input  logic [15:0]        req_data,
    input  logic [NUM_BLK-1:0] req_blk_mask,
    input  logic [NUM_BLK-1:0] prot_mask,
    input  logic               rd_en,
    input  logic [AW-1:0]      rd_addr,
    output logic [15:0]        rd_data,
    output logic               ready_n,
    output logic [AW-1:0]      arr_raddr,
    input  logic [15:0]        arr_rdata,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [15:0]        wr_data,
    input  logic [15:0]        wr_old
);
    localparam int BW   = $clog2(BLK_WORDS);
    localparam int MAXC = imax3(PROG_BYTE_CYC, PROG_WORD_CYC, REJ_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    pec_state_e          state;
    logic                held;
    logic [NUM_BLK-1:0]  emask;
    logic [AW-1:0]       p_addr;
    logic [WORD_W-1:0]   p_data;
    logic                p_byte;
    logic                p_lane;
    logic [CW-1:0]       cnt;
    logic                rej_poll;

    pec_op_e             op;
    logic                is_prog, is_erase, is_susp;
    logic                accept_prog;
    logic [NUM_BLK-1:0]  era_eff;
    logic [CW-1:0]       prog_len;
    logic                running;
    logic                walk_start, walk_run, erase_we, erase_done;
    logic [AW-1:0]       walk_addr;
    logic                prog_we;
    logic                stat_sel, blk_hit, poll;
    logic [7:0]          status;

    assign op       = pec_op_e'(req_op);
    assign is_prog  = req_valid && (op == OP_PROG_BYTE || op == OP_PROG_WORD);
    assign is_erase = req_valid && (op == OP_ERASE_SEL || op == OP_ERASE_ALL);
    assign is_susp  = req_valid && op == OP_SUSPEND;
    assign era_eff  = ((op == OP_ERASE_ALL) ? {NUM_BLK{1'b1}} : req_blk_mask) & ~prot_mask;
    assign prog_len = (op == OP_PROG_BYTE) ? CW'(PROG_BYTE_CYC - 1) : CW'(PROG_WORD_CYC - 1);
    assign running  = state inside {ST_PROG, ST_ERASE, ST_REJ};
    assign ready_n  = !running;

    assign accept_prog = is_prog && (state == ST_IDLE ||
                         (state == ST_SUSP && !emask[req_addr[AW-1:BW]]));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            held     <= 1'b0;
            emask    <= '0;
            p_addr   <= '0;
            p_data   <= '0;
            p_byte   <= 1'b0;
            p_lane   <= 1'b0;
            cnt      <= '0;
            rej_poll <= 1'b0;
        end else if (accept_prog) begin
            p_addr <= req_addr;
            p_data <= req_data;
            p_byte <= (op == OP_PROG_BYTE);
            p_lane <= req_lane;
            if (prot_mask[req_addr[AW-1:BW]]) begin
                state    <= ST_REJ;
                cnt      <= CW'(REJ_CYC - 1);
                rej_poll <= ~req_data[7];
            end else begin
                state <= ST_PROG;
                cnt   <= prog_len;
            end
        end else begin
            case (state)
                ST_IDLE: if (is_erase) begin
                    if (|era_eff) begin
                        emask <= era_eff;
                        state <= ST_ERASE;
                    end else begin
                        state    <= ST_REJ;
                        cnt      <= CW'(REJ_CYC - 1);
                        rej_poll <= 1'b0;
                    end
                end
                ST_ERASE: if (is_susp) begin
                    state <= ST_SUSP;
                    held  <= 1'b1;
                end else if (erase_done) begin
                    state <= ST_IDLE;
                    emask <= '0;
                end
                ST_SUSP: if (req_valid && op == OP_RESUME) begin
                    state <= ST_ERASE;
                    held  <= 1'b0;
                end else if (req_valid && op == OP_ABANDON) begin
                    state <= ST_IDLE;
                    held  <= 1'b0;
                    emask <= '0;
                end
                ST_PROG, ST_REJ: if (cnt == '0) begin
                    state <= held ? ST_SUSP : ST_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign walk_start = (state == ST_IDLE) && is_erase && !accept_prog && (|era_eff);
    assign walk_run   = (state == ST_ERASE) && !is_susp;

    pec_erase_walk #(
        .NUM_BLK  (NUM_BLK),
        .BLK_WORDS(BLK_WORDS),
        .CELL_CYC (ERASE_CELL_CYC),
        .AW       (AW)
    ) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (walk_start),
        .run     (walk_run),
        .blk_mask(emask),
        .we      (erase_we),
        .addr    (walk_addr),
        .done    (erase_done)
    );

    assign prog_we = (state == ST_PROG) && cnt == '0;
    assign wr_en   = prog_we || erase_we;
    assign wr_addr = prog_we ? p_addr : walk_addr;
    assign wr_data = prog_we ? prog_merge(wr_old, p_data, p_byte, p_lane) : {WORD_W{1'b1}};

    // Host read path: status while busy or on a suspended erase's blocks.
    assign stat_sel  = running || (state == ST_SUSP && emask[rd_addr[AW-1:BW]]);
    assign blk_hit   = emask[rd_addr[AW-1:BW]] && (state == ST_ERASE || held);
    assign arr_raddr = rd_addr;

    always_comb begin
        case (state)
            ST_PROG: poll = ~p_data[7];
            ST_REJ:  poll = rej_poll;
            ST_SUSP: poll = 1'b1;
            default: poll = 1'b0;
        endcase
    end

    pec_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .stat_rd(rd_en && stat_sel),
        .running(running),
        .blk_hit(blk_hit),
        .poll   (poll),
        .status (status)
    );

    assign rd_data = stat_sel ? {8'h00, status} : arr_rdata;

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && state == ST_PROG) |-> ((wr_data & ~wr_old) == '0)); // R4
    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        erase_we |-> (wr_data == 16'hFFFF)); // R5
    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(prog_we && erase_we)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !wr_en); // R1
    AST_REJ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJ) |-> !wr_en); // R7
    AST_SUSP_READY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SUSP) |-> (ready_n && !wr_en)); // R11

endmodule

// File: tb/pe_sequencer_tb.sv
module pe_sequencer_tb;
    localparam int NB  = 4;
    localparam int BWD = 8;
    localparam int PB  = 10;
    localparam int PW  = 16;
    localparam int EC  = 4;
    localparam int RJ  = 3;
    localparam int DEP = NB * BWD;
    localparam int AW  = $clog2(DEP);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic req_lane = 1'b0;
    logic [15:0] req_data = '0;
    logic [NB-1:0] req_blk_mask = '0;
    logic [NB-1:0] prot_mask = 4'b1000;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic ready_n;
    logic [AW-1:0] arr_raddr;
    logic [15:0] arr_rdata;
    logic wr_en;
    logic [AW-1:0] wr_addr;
    logic [15:0] wr_data;
    logic [15:0] wr_old;

    logic [15:0] mem [DEP];
    logic [15:0] ref_mem [DEP];

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit finished = 0;

    always #10 clk = ~clk;

    pe_sequencer #(.NUM_BLK(NB), .BLK_WORDS(BWD), .PROG_BYTE_CYC(PB), .PROG_WORD_CYC(PW),
                   .ERASE_CELL_CYC(EC), .REJ_CYC(RJ)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_lane(req_lane), .req_data(req_data), .req_blk_mask(req_blk_mask),
        .prot_mask(prot_mask), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ready_n(ready_n), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_old(wr_old));

    // Array storage environment
    assign arr_rdata = mem[arr_raddr];
    assign wr_old    = mem[wr_addr];
    always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;

    // Behavioural model: 0 idle, 1 program, 2 erase, 3 suspended, 4 refusing
    int m_st = 0, m_left = 0, m_blk = 0;
    bit m_held = 0, m_rpoll = 0, m_t6 = 0, m_t2 = 0;
    bit [NB-1:0] m_em = '0, m_sel = '0;
    int pa = 0; logic [15:0] pd = '0; bit pbyte = 0, plane = 0;
    int eq_cyc[$]; int eq_adr[$]; bit eq_wr[$];

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_held = 0; m_em = '0; m_left = 0; m_t6 = 0; m_t2 = 0;
            eq_cyc.delete(); eq_adr.delete(); eq_wr.delete();
        end else begin
            m_blk = int'(req_addr) / BWD;
            if (req_valid && (req_op == 3'd1 || req_op == 3'd2) &&
                (m_st == 0 || (m_st == 3 && !m_em[m_blk]))) begin
                pa = int'(req_addr); pd = req_data; pbyte = (req_op == 3'd1); plane = req_lane;
                if (prot_mask[m_blk]) begin m_st = 4; m_left = RJ; m_rpoll = ~req_data[7]; end
                else begin m_st = 1; m_left = pbyte ? PB : PW; end
            end else begin
                case (m_st)
                    0: if (req_valid && (req_op == 3'd3 || req_op == 3'd4)) begin
                        m_sel = ((req_op == 3'd4) ? {NB{1'b1}} : req_blk_mask) & ~prot_mask;
                        if (m_sel == '0) begin m_st = 4; m_left = RJ; m_rpoll = 0; end
                        else begin
                            m_em = m_sel; m_st = 2;
                            for (int a = 0; a < DEP; a++) begin
                                eq_adr.push_back(a);
                                eq_wr.push_back(m_sel[a / BWD]);
                                eq_cyc.push_back(m_sel[a / BWD] ? EC : 1);
                            end
                        end
                    end
                    1: begin
                        m_left--;
                        if (m_left == 0) begin
                            if (!pbyte) ref_mem[pa] = ref_mem[pa] & pd;
                            else if (plane) ref_mem[pa] = ref_mem[pa] & {pd[7:0], 8'hFF};
                            else ref_mem[pa] = ref_mem[pa] & {8'hFF, pd[7:0]};
                            m_st = m_held ? 3 : 0;
                        end
                    end
                    4: begin
                        m_left--;
                        if (m_left == 0) m_st = m_held ? 3 : 0;
                    end
                    2: if (req_valid && req_op == 3'd5) begin m_st = 3; m_held = 1; end
                    else begin
                        eq_cyc[0] = eq_cyc[0] - 1;
                        if (eq_cyc[0] == 0) begin
                            if (eq_wr[0]) ref_mem[eq_adr[0]] = 16'hFFFF;
                            void'(eq_cyc.pop_front()); void'(eq_adr.pop_front()); void'(eq_wr.pop_front());
                            if (eq_cyc.size() == 0) begin m_st = 0; m_em = '0; end
                        end
                    end
                    3: if (req_valid && req_op == 3'd6) begin m_st = 2; m_held = 0; end
                    else if (req_valid && req_op == 3'd7) begin m_st = 0; m_held = 0; m_em = '0; end
                    default: m_st = 0;
                endcase
            end
        end
    end

    // Per-clock comparison of busy flag and array contents
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit ok_arr;
            n_chk++;
            if (ready_n !== !(m_st == 1 || m_st == 2 || m_st == 4)) begin
                n_bad++;
                $display("FAIL %s busy flag: ready_n=%0b expected %0b", cur_req, ready_n,
                         !(m_st == 1 || m_st == 2 || m_st == 4));
            end
            ok_arr = 1;
            for (int a = 0; a < DEP; a++) if (mem[a] !== ref_mem[a]) ok_arr = 0;
            n_chk++;
            if (!ok_arr) begin
                n_bad++;
                for (int a = 0; a < DEP; a++)
                    if (mem[a] !== ref_mem[a]) begin
                        $display("FAIL %s array word %0d: got %h expected %h", cur_req, a, mem[a], ref_mem[a]);
                        break;
                    end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [15:0] exp;
        bit ssel, runb, poll;
        int b;
        b = a / BWD;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(a);
        #5;
        runb = (m_st == 1 || m_st == 2 || m_st == 4);
        ssel = runb || (m_st == 3 && m_em[b]);
        case (m_st)
            1: poll = ~pd[7];
            4: poll = m_rpoll;
            3: poll = 1'b1;
            default: poll = 1'b0;
        endcase
        exp = ssel ? {8'h00, poll, m_t6, 3'b000, m_t2, 2'b00} : ref_mem[a];
        check(rd_data === exp, tag, rd_data, exp);
        if (ssel && runb) m_t6 = ~m_t6;
        if (ssel && m_em[b] && (m_st == 2 || m_held)) m_t2 = ~m_t2;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic do_req(input int op, input int a, input bit lane, input logic [15:0] d, input logic [NB-1:0] msk);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = AW'(a); req_lane = lane;
        req_data = d; req_blk_mask = msk;
        @(posedge clk); #1 req_valid = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (ready_n) break;
        end
    endtask

    initial begin
        #(20 * 60000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired in %s: got 0 expected 1", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            finished = 1;
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEP; a++) begin
            mem[a] = 16'hFFFF ^ 16'(a * 16'h0111);
            ref_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        @(negedge clk);
        check(ready_n === 1'b1, "R1 ready after reset", {15'd0, ready_n}, 16'd1);
        rd_chk(0, "R1 array read after reset");
        rd_chk(13, "R1 array read after reset");

        cur_req = "R2";
        do_req(2, 2, 0, 16'h1234, '0);
        rd_chk(30, "R8 poll during word program");
        rd_chk(30, "R9 toggle on second read");
        do_req(3, 0, 0, 16'h0, 4'b0001);   // ignored while busy (R12)
        wait_ready();
        rd_chk(2, "R2 word program result");
        check(ref_mem[2] === ((16'hFFFF ^ 16'h0222) & 16'h1234), "R2 expected value",
              ref_mem[2], (16'hFFFF ^ 16'h0222) & 16'h1234);

        cur_req = "R3";
        do_req(1, 3, 1, 16'h005A, '0);
        rd_chk(3, "R8 poll during byte program");
        wait_ready();
        rd_chk(3, "R3 upper lane program");
        do_req(1, 4, 0, 16'hFF81, '0);
        wait_ready();
        rd_chk(4, "R3 lower lane program");

        cur_req = "R4";
        do_req(2, 2, 0, 16'hFFFF, '0);
        wait_ready();
        rd_chk(2, "R4 no bit returns to one");

        cur_req = "R7";
        do_req(2, 25, 0, 16'h0000, '0);
        rd_chk(25, "R7 poll while refusing");
        wait_ready();
        rd_chk(25, "R7 protected word unchanged");
        do_req(3, 0, 0, 16'h0, 4'b1000);
        wait_ready();
        rd_chk(26, "R7 protected erase unchanged");

        cur_req = "R5";
        do_req(3, 0, 0, 16'h0, 4'b0001);
        rd_chk(1, "R10 toggle2 on erasing block");
        rd_chk(1, "R10 toggle2 on erasing block again");
        rd_chk(9, "R10 no toggle2 outside erase");
        rd_chk(9, "R10 no toggle2 outside erase again");
        wait_ready();
        rd_chk(0, "R5 erased word");
        rd_chk(7, "R5 erased word");
        rd_chk(8, "R5 neighbour block untouched");

        cur_req = "R11";
        do_req(3, 0, 0, 16'h0, 4'b0010);
        repeat (10) @(negedge clk);
        do_req(5, 0, 0, 16'h0, '0);
        @(negedge clk);
        check(ready_n === 1'b1, "R11 ready while suspended", {15'd0, ready_n}, 16'd1);
        rd_chk(20, "R11 array read outside erase");
        rd_chk(9, "R11 status read inside erase");
        rd_chk(9, "R9 toggle stable while suspended");
        cur_req = "R12";
        do_req(2, 17, 0, 16'h00FF, '0);
        rd_chk(9, "R10 toggle2 during program in suspend");
        wait_ready();
        rd_chk(17, "R12 program during suspend");
        do_req(2, 10, 0, 16'h0000, '0);
        repeat (3) @(negedge clk);
        check(ready_n === 1'b1, "R12 program to erasing block ignored", {15'd0, ready_n}, 16'd1);
        cur_req = "R13";
        do_req(6, 0, 0, 16'h0, '0);
        wait_ready();
        rd_chk(8, "R13 resumed erase completes");
        rd_chk(15, "R13 resumed erase completes");
        rd_chk(17, "R13 programmed word survives");

        cur_req = "R6";
        do_req(4, 0, 0, 16'h0, '0);
        wait_ready();
        rd_chk(2, "R6 chip erase");
        rd_chk(17, "R6 chip erase");
        rd_chk(24, "R6 protected block kept");

        cur_req = "R13";
        do_req(2, 20, 0, 16'h0F0F, '0);
        wait_ready();
        do_req(3, 0, 0, 16'h0, 4'b0100);
        repeat (6) @(negedge clk);
        do_req(5, 0, 0, 16'h0, '0);
        do_req(7, 0, 0, 16'h0, '0);
        @(negedge clk);
        check(ready_n === 1'b1, "R13 abandon ready", {15'd0, ready_n}, 16'd1);
        rd_chk(20, "R13 array read after abandon");

        cur_req = "R14";
        do_req(2, 5, 0, 16'h0000, '0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(ready_n === 1'b1, "R14 reset aborts program", {15'd0, ready_n}, 16'd1);
        rd_chk(5, "R14 array unchanged after abort");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule